// File: doc/BRIEF.md
# Masked Two-Stage Capture Trigger Sequencer

This block sits in front of a sample-capture engine and decides the clock cycle in which capture begins. Every clock it looks at a wide bus of already-synchronised input samples and compares it, under a bit mask, against two programmed patterns. The first pattern arms the sequencer and the second one triggers it. An optional post-trigger delay can be added, counted in sample-clock ticks. When the sequence completes, the block emits a one-cycle capture-start pulse. It then reports a triggered status until the capture engine signals completion.

Software or a controller loads four settings while the sequencer is idle: the mask, the arm value, the trigger value and the delay. A start command then launches a run. The arm stage is skipped when the arm value equals the mask. A mask of all zeros fires the capture immediately. An abort command stops any run and returns the sequencer to idle.

Top module: `lat_trig_seq`

## Requirements
- R1: A pattern hits when `(sample_i & mask) == value`; the arm stage and the trigger stage both use this rule, with the same mask.
- R2: When the mask is all zeros, a start in idle makes `cap_start_o` high in the very next cycle, and no sample is examined.
- R3: Trigger-value bits in positions where the mask is 0 are forced to zero, so they never prevent a trigger hit.
- R4: When the arm value equals the mask, the arm stage is skipped: `armed_o` is high in the cycle after the start.
- R5: Otherwise the sequencer first waits for an arm hit (`armed_o` low). Trigger hits seen before the arm hit are ignored. After the arm hit, `armed_o` goes high on the next cycle.
- R6: With a delay of 0, `cap_start_o` is high in the cycle after the clock edge on which the trigger hit was sampled.
- R7: With a delay of D > 0, `cap_start_o` comes D cycles later than in the zero-delay case. `delaying_o` is high in the cycles between the trigger hit and the pulse.
- R8: Configuration writes (`cfg_sel_i`: 0 = mask, 1 = arm value, 2 = trigger value, 3 = delay, the delay taken from the low `DLY_W` bits) take effect only in idle. Writes made during a run are ignored.
- R9: `cap_start_o` lasts exactly one cycle. From that cycle, `triggered_o` stays high until `cap_done_i` or `abort_i` is seen, and the sequencer then returns to idle.
- R10: `abort_i` in any state clears every status output at the next cycle and suppresses any capture-start pulse that would otherwise have been issued on that edge.
- R11: After reset all outputs are low. At most one of `armed_o`, `delaying_o` and `triggered_o` is high at a time. `start_i` is ignored outside idle, and `cap_done_i` is ignored outside the triggered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | W | Synchronised input sample bus |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_data_i | input | W | Configuration write data |
| start_i | input | 1 | Launch a run (idle only) |
| abort_i | input | 1 | Return to idle immediately |
| cap_done_i | input | 1 | Capture engine finished |
| cap_start_o | output | 1 | One-cycle capture-start pulse |
| armed_o | output | 1 | Arm satisfied, waiting for trigger |
| delaying_o | output | 1 | Counting post-trigger delay |
| triggered_o | output | 1 | Capture launched, awaiting done |

## Verification
The bench targets the following corner cases:

- A zero mask must fire on the cycle after start. A design that still waited for a sample would miss that pulse.
- A trigger value with ones outside the mask must still hit. A design that compared the raw value would hang.
- A trigger pattern presented before the arm pattern must be ignored. A design that skipped the arm stage would pulse too early.
- A non-zero delay is checked for the exact pulse cycle, so an off-by-one counter lands on the wrong cycle in the scoreboard.
- Aborts are placed on the same edge as a trigger hit, in the middle of a delay and in the triggered state. A design that let the pulse leak would produce an unexpected scoreboard entry.
- Configuration writes and start commands are issued mid-run. A design that accepted them would either move the trigger or clear the armed flag.

// File: rtl/lat_pkg.sv
package lat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARM   = 3'd1,
      ST_TRIG  = 3'd2,
      ST_DLY   = 3'd3,
      ST_HOLD  = 3'd4
   } lat_state_e;

   typedef enum logic [1:0] {
      CFG_MASK  = 2'd0,
      CFG_ARM   = 2'd1,
      CFG_TRIG  = 2'd2,
      CFG_DELAY = 2'd3
   } lat_cfg_sel_e;

endpackage

// File: rtl/lat_mask_cmp.sv
// Masked equality compare: each bit either is don't-care or must match.
module lat_mask_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] sample_i,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] value_i,
   output logic         hit_o
);

   logic [W-1:0] bit_ok;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_ok[i] = ~mask_i[i] | (sample_i[i] == value_i[i]);
   end

   assign hit_o = &bit_ok;

endmodule

// File: rtl/lat_dly_cnt.sv
// Post-trigger delay down counter; flags the final tick.
module lat_dly_cnt #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic [DLY_W-1:0] load_val_i,
   input  logic             en_i,
   output logic             last_o
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (en_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign last_o = (cnt_q == ONE);

endmodule

// File: rtl/lat_cfg_bank.sv
// Configuration bank: written only while idle; trigger value forced under mask.
module lat_cfg_bank
   import lat_pkg::*;
#(
   parameter int W     = 32,
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle_i,
   input  logic             we_i,
   input  logic [1:0]       sel_i,
   input  logic [W-1:0]     data_i,
   output logic [W-1:0]     mask_o,
   output logic [W-1:0]     arm_o,
   output logic [W-1:0]     trig_o,
   output logic [DLY_W-1:0] dly_o,
   output logic             mask_zero_o,
   output logic             arm_skip_o,
   output logic             dly_zero_o
);

   logic [W-1:0]     mask_q;
   logic [W-1:0]     arm_q;
   logic [W-1:0]     trig_q;
   logic [DLY_W-1:0] dly_q;
   logic             wr_ok;

   assign wr_ok = we_i && idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         arm_q  <= '0;
         trig_q <= '0;
         dly_q  <= '0;
      end else if (wr_ok) begin
         unique case (lat_cfg_sel_e'(sel_i))
            CFG_MASK:  mask_q <= data_i;
            CFG_ARM:   arm_q  <= data_i;
            CFG_TRIG:  trig_q <= data_i;
            CFG_DELAY: dly_q  <= data_i[DLY_W-1:0];
            default:   ;
         endcase
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_force
      assign trig_o[i] = trig_q[i] & mask_q[i];
   end

   assign mask_o      = mask_q;
   assign arm_o       = arm_q;
   assign dly_o       = dly_q;
   assign mask_zero_o = (mask_q == '0);
   assign arm_skip_o  = (arm_q == mask_q);
   assign dly_zero_o  = (dly_q == '0);

endmodule

// File: rtl/lat_trig_seq.sv
// Arm-then-trigger capture sequencer with optional post-trigger delay.
module lat_trig_seq
   import lat_pkg::*;
#(
   parameter int W     = 32,
   parameter int DLY_W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample_i,
   input  logic         cfg_we_i,
   input  logic [1:0]   cfg_sel_i,
   input  logic [W-1:0] cfg_data_i,
   input  logic         start_i,
   input  logic         abort_i,
   input  logic         cap_done_i,
   output logic         cap_start_o,
   output logic         armed_o,
   output logic         delaying_o,
   output logic         triggered_o
);

   if (W < 1) begin : g_bad_w
      $error("lat_trig_seq: W must be at least 1");
   end
   if ((DLY_W < 1) || (DLY_W > W)) begin : g_bad_dly
      $error("lat_trig_seq: DLY_W must lie in 1..W");
   end

   lat_state_e       st_q, st_d;
   logic             fire_d, fire_q;
   logic             load_d;
   logic             is_idle;
   logic [W-1:0]     mask_w, arm_w, trig_w;
   logic [DLY_W-1:0] dly_w;
   logic             mask_zero, arm_skip, dly_zero;
   logic             arm_hit, trig_hit, dly_last;

   assign is_idle = (st_q == ST_IDLE);

   lat_cfg_bank #(.W(W), .DLY_W(DLY_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle_i      (is_idle),
      .we_i        (cfg_we_i),
      .sel_i       (cfg_sel_i),
      .data_i      (cfg_data_i),
      .mask_o      (mask_w),
      .arm_o       (arm_w),
      .trig_o      (trig_w),
      .dly_o       (dly_w),
      .mask_zero_o (mask_zero),
      .arm_skip_o  (arm_skip),
      .dly_zero_o  (dly_zero)
   );

   lat_mask_cmp #(.W(W)) u_arm_cmp (
      .sample_i (sample_i),
      .mask_i   (mask_w),
      .value_i  (arm_w),
      .hit_o    (arm_hit)
   );

   lat_mask_cmp #(.W(W)) u_trig_cmp (
      .sample_i (sample_i),
      .mask_i   (mask_w),
      .value_i  (trig_w),
      .hit_o    (trig_hit)
   );

   lat_dly_cnt #(.DLY_W(DLY_W)) u_dly (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (abort_i),
      .load_i     (load_d),
      .load_val_i (dly_w),
      .en_i       (st_q == ST_DLY),
      .last_o     (dly_last)
   );

   always_comb begin
      st_d   = st_q;
      fire_d = 1'b0;
      load_d = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (mask_zero) begin
                  fire_d = 1'b1;
                  st_d   = ST_HOLD;
               end else if (arm_skip) begin
                  st_d = ST_TRIG;
               end else begin
                  st_d = ST_ARM;
               end
            end
         end
         ST_ARM: begin
            if (arm_hit) st_d = ST_TRIG;
         end
         ST_TRIG: begin
            if (trig_hit) begin
               if (dly_zero) begin
                  fire_d = 1'b1;
                  st_d   = ST_HOLD;
               end else begin
                  load_d = 1'b1;
                  st_d   = ST_DLY;
               end
            end
         end
         ST_DLY: begin
            if (dly_last) begin
               fire_d = 1'b1;
               st_d   = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (cap_done_i) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
      if (abort_i) begin
         st_d   = ST_IDLE;
         fire_d = 1'b0;
         load_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fire_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         fire_q <= fire_d;
      end
   end

   assign cap_start_o = fire_q;
   assign armed_o     = (st_q == ST_TRIG);
   assign delaying_o  = (st_q == ST_DLY);
   assign triggered_o = (st_q == ST_HOLD);

endmodule

// File: rtl/lat_trig_seq_chk.sv
// Property checker attached to lat_trig_seq.
module lat_trig_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic abort_i,
   input logic cap_done_i,
   input logic cap_start_o,
   input logic armed_o,
   input logic delaying_o,
   input logic triggered_o,
   input logic idle_s,
   input logic mask_zero_s
);

   p_zero_mask_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_s && start_i && !abort_i && mask_zero_s) |=> cap_start_o);

   p_delay_ends_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(delaying_o) && !$past(abort_i)) |-> cap_start_o);

   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start_o |=> !cap_start_o);

   p_pulse_with_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_start_o |-> triggered_o);

   p_hold_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered_o && !cap_done_i && !abort_i) |=> triggered_o);

   p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !(cap_start_o || armed_o || delaying_o || triggered_o));

   p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({armed_o, delaying_o, triggered_o}));

endmodule

bind lat_trig_seq lat_trig_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .abort_i     (abort_i),
   .cap_done_i  (cap_done_i),
   .cap_start_o (cap_start_o),
   .armed_o     (armed_o),
   .delaying_o  (delaying_o),
   .triggered_o (triggered_o),
   .idle_s      (is_idle),
   .mask_zero_s (mask_zero)
);

// File: tb/test_lat_trig_seq.sv
module test_lat_trig_seq;

   localparam int W     = 32;
   localparam int DLY_W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] sample = '0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = '0;
   logic [W-1:0] cfg_data = '0;
   logic         start = 1'b0;
   logic         abort = 1'b0;
   logic         cap_done = 1'b0;
   logic         cap_start, armed, delaying, triggered;

   int cyc = 0;
   int nvec = 0;
   int nerr = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   lat_trig_seq #(.W(W), .DLY_W(DLY_W)) i_lat_trig_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_i    (sample),
      .cfg_we_i    (cfg_we),
      .cfg_sel_i   (cfg_sel),
      .cfg_data_i  (cfg_data),
      .start_i     (start),
      .abort_i     (abort),
      .cap_done_i  (cap_done),
      .cap_start_o (cap_start),
      .armed_o     (armed),
      .delaying_o  (delaying),
      .triggered_o (triggered)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Scoreboard monitor: every capture pulse must match a queued cycle.
   always @(negedge clk) begin
      if (rst_n && cap_start) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R9/R10 unexpected pulse", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(cyc == e, "R6/R7 pulse cycle", cyc, e);
         end
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [W-1:0] d);
      step();
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic go();
      step();
      start = 1'b1;
      step();
      start = 1'b0;
   endtask

   task automatic finish_run(input string req);
      cap_done = 1'b1;
      step();
      cap_done = 1'b0;
      chk(!triggered && !armed && !delaying, req, {armed, delaying, triggered}, 0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk({cap_start, armed, delaying, triggered} == 4'b0, "R11 reset outputs",
          {cap_start, armed, delaying, triggered}, 0);

      // R2 zero mask fires immediately
      cfg(2'd0, 32'h0);
      step();
      start = 1'b1;
      exp_q.push_back(cyc + 1);
      step();
      start = 1'b0;
      chk(triggered, "R9 triggered after pulse", triggered, 1);
      step(3);
      chk(triggered, "R9 triggered held", triggered, 1);
      finish_run("R9 done returns idle");

      // R4 arm skipped, R6 zero delay, R1 masked match
      cfg(2'd0, 32'h0000_00FF);
      cfg(2'd1, 32'h0000_00FF);
      cfg(2'd2, 32'h0000_005A);
      cfg(2'd3, 32'h0);
      sample = 32'h0000_005B;
      go();
      chk(armed, "R4 arm skipped", armed, 1);
      step(2);
      sample = 32'hABCD_EF5A;
      exp_q.push_back(cyc + 1);
      step();
      chk(triggered, "R1 masked hit", triggered, 1);
      finish_run("R6 done");

      // R3 trigger value bits outside mask ignored
      cfg(2'd2, 32'hFFFF_FF3C);
      sample = 32'h0000_003D;
      go();
      step();
      sample = 32'h0000_003C;
      exp_q.push_back(cyc + 1);
      step();
      chk(triggered, "R3 forced trigger value", triggered, 1);
      finish_run("R3 done");

      // R5 arm stage before trigger
      cfg(2'd0, 32'h0000_00F0);
      cfg(2'd1, 32'h0000_0010);
      cfg(2'd2, 32'h0000_0020);
      sample = '0;
      go();
      sample = 32'h0000_0020;
      step(3);
      chk(!armed && !triggered, "R5 trigger before arm ignored", {armed, triggered}, 0);
      sample = 32'h0000_001F;
      step();
      chk(armed, "R5 armed after arm hit", armed, 1);
      sample = 32'h0000_002F;
      exp_q.push_back(cyc + 1);
      step();
      chk(triggered, "R5 trigger after arm", triggered, 1);
      finish_run("R5 done");

      // R7 delay of 5
      cfg(2'd0, 32'h0000_00FF);
      cfg(2'd1, 32'h0000_00FF);
      cfg(2'd2, 32'h0000_0077);
      cfg(2'd3, 32'd5);
      sample = '0;
      go();
      sample = 32'h0000_0077;
      exp_q.push_back(cyc + 1 + 5);
      step();
      sample = '0;
      chk(delaying && !triggered, "R7 delaying", {delaying, triggered}, 2);
      step(3);
      chk(delaying, "R7 still delaying", delaying, 1);
      step(2);
      chk(triggered, "R7 triggered after delay", triggered, 1);
      finish_run("R7 done");

      // R8 config writes ignored during a run
      cfg(2'd3, 32'd0);
      go();
      cfg(2'd2, 32'h0000_0011);
      cfg(2'd0, 32'h0);
      sample = 32'h0000_0011;
      step(3);
      chk(armed && !triggered, "R8 mid-run writes ignored", {armed, triggered}, 2);
      sample = 32'h0000_0077;
      exp_q.push_back(cyc + 1);
      step();
      sample = '0;
      chk(triggered, "R8 old trigger still used", triggered, 1);
      finish_run("R8 done");

      // R10 abort while waiting for trigger
      go();
      abort = 1'b1;
      step();
      abort = 1'b0;
      chk(!armed, "R10 abort in wait", armed, 0);
      // R10 abort on the same edge as a trigger hit
      go();
      sample = 32'h0000_0077;
      abort = 1'b1;
      step();
      abort = 1'b0;
      sample = '0;
      chk(!triggered && !armed, "R10 abort suppresses pulse", {armed, triggered}, 0);
      // R10 abort during delay
      cfg(2'd3, 32'd3);
      go();
      sample = 32'h0000_0077;
      step();
      sample = '0;
      chk(delaying, "R10 delay entered", delaying, 1);
      abort = 1'b1;
      step();
      abort = 1'b0;
      chk(!delaying, "R10 abort in delay", delaying, 0);
      step(5);
      // R10 abort in triggered state
      cfg(2'd3, 32'd0);
      go();
      sample = 32'h0000_0077;
      exp_q.push_back(cyc + 1);
      step();
      sample = '0;
      abort = 1'b1;
      step();
      abort = 1'b0;
      chk(!triggered, "R10 abort in hold", triggered, 0);

      // R11 start ignored in hold, done ignored in wait
      go();
      sample = 32'h0000_0077;
      exp_q.push_back(cyc + 1);
      step();
      sample = '0;
      start = 1'b1;
      step();
      start = 1'b0;
      chk(triggered && !armed, "R11 start ignored in hold", {armed, triggered}, 1);
      finish_run("R11 done");
      go();
      cap_done = 1'b1;
      step();
      cap_done = 1'b0;
      chk(armed, "R11 done ignored while waiting", armed, 1);
      abort = 1'b1;
      step();
      abort = 1'b0;

      step(4);
      chk(exp_q.size() == 0, "R9 all expected pulses seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nvec++;
         nerr++;
         $display("FAIL watchdog: actual %0d expected done", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

endmodule